// File: doc/BRIEF.md
# One-Time-Programmable Store Programming Port

This block is the device-side gateway through which an external programmer fills and reads back an on-chip one-time-programmable byte store. A 4-bit mode-select input picks one of four operations: address clear, write, verify or inhibit. No address pins exist. An internal address counter moves forward by one location for every four rising edges on a dedicated pulse input, and the clear mode resets it.

Data moves as one byte, split across two 4-bit ports that carry the low and high nibbles. Write mode stores the byte on the input ports into the current location. Verify mode drives the stored byte out, with an output enable. In every other mode the bus is released. A single programming-enable input stands in for the raised supply and programming voltage: while it is low the port does nothing. The store is a behavioural array of the stated size. Unwritten locations read as all ones.

Top module: `otp_prog_port`

## Requirements
- R1: After reset the output enable and the out-of-range flag are low, and the address counter is at location 0.
- R2: With `mode_sel` bit i standing for select line i, the code 4'b0101 selects address clear, 4'b1110 selects write, 4'b1100 selects verify, and 4'b11?1 selects inhibit.
- R3: Address clear sets the address and the pulse sub-count to zero and lowers the out-of-range flag, so that pulses counted before the clear do not carry over.
- R4: While enabled and not in clear mode, every fourth rising edge of `pulse_in` moves the address up by one. This happens in write, verify, inhibit and unrecognised modes alike.
- R5: On entry to write mode the byte {`din_hi`,`din_lo`} is stored at the current address, once per entry.
- R6: In verify mode `dout_oe` is high and {`dout_hi`,`dout_lo`} shows the byte stored at the current address, at most three clock cycles after the mode or the address changes. A location never written reads 8'hFF.
- R7: `dout_oe` is low and the data outputs are zero in every mode other than verify.
- R8: The address stops at the last location (8063, 0x1F7F). The fourth pulse at that location raises `addr_oor` instead of wrapping. While `addr_oor` is high, writes are ignored, and it stays high until a clear.
- R9: Any code outside those listed in R2 acts as inhibit: nothing is stored and the bus is not driven.
- R10: While `prog_en` is low no byte is stored, the bus is not driven, pulses are not counted and the clear code has no effect.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_en | input | 1 | Programming-mode enable |
| mode_sel | input | 4 | Operation select lines |
| pulse_in | input | 1 | Address step pulses, four per location |
| din_lo | input | 4 | Write data, low nibble |
| din_hi | input | 4 | Write data, high nibble |
| dout_lo | output | 4 | Read data, low nibble |
| dout_hi | output | 4 | Read data, high nibble |
| dout_oe | output | 1 | Read data drive enable |
| addr_oor | output | 1 | Address ran past the last location |

## Verification
The bench goes after four corner cases:
- Partial pulse groups cut short by a clear. A sub-count that survives the clear would step the address one location early, and read-back would land on the wrong byte.
- The final location. A counter that wraps would move to location 0, and the bench would see location 0 data where the last byte should be. It would also see no overflow flag.
- Writes attempted with the enable low, in unknown codes, or after overflow. Any leak would show up later on read-back as a changed byte.
- The bus enable in each non-verify mode. A port that drives the bus in those modes would fight the programmer's write data.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [1:0] {
    OP_INHIBIT = 2'd0,
    OP_CLEAR   = 2'd1,
    OP_WRITE   = 2'd2,
    OP_VERIFY  = 2'd3
  } otp_op_e;

  localparam logic [3:0] SEL_CLEAR  = 4'b0101;
  localparam logic [3:0] SEL_WRITE  = 4'b1110;
  localparam logic [3:0] SEL_VERIFY = 4'b1100;
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic       en,
  input  logic [3:0] sel,
  output otp_op_e    op
);
  always_comb begin
    op = OP_INHIBIT;
    if (en) begin
      unique case (sel)
        SEL_CLEAR:  op = OP_CLEAR;
        SEL_WRITE:  op = OP_WRITE;
        SEL_VERIFY: op = OP_VERIFY;
        default:    op = OP_INHIBIT;
      endcase
    end
  end
endmodule

// File: rtl/otp_addr_ctr.sv
module otp_addr_ctr #(
  parameter int DEPTH = 8064,
  parameter int PULSES_PER_STEP = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(PULSES_PER_STEP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          oor
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [SW-1:0] SUB_TOP = SW'(PULSES_PER_STEP - 1);

  logic [SW-1:0] sub;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      addr <= '0;
      sub  <= '0;
      oor  <= 1'b0;
    end else if (step) begin
      sub <= (sub == SUB_TOP) ? '0 : sub + 1'b1;
      if (sub == SUB_TOP) begin
        if (addr == LAST) oor <= 1'b1;
        else              addr <= addr + 1'b1;
      end
    end
  end

  a_r8_addr_bound: assert property (@(posedge clk) disable iff (rst)
    addr <= LAST);
  a_r4_step_once: assert property (@(posedge clk) disable iff (rst)
    (step && !clear && sub == SUB_TOP && addr != LAST) |=> addr == $past(addr) + 1'b1);
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !clear) |=> $stable(addr));
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clear |=> (addr == '0 && !oor));
  a_r8_oor_sticky: assert property (@(posedge clk) disable iff (rst)
    (oor && !clear) |=> oor);
endmodule

// File: rtl/otp_store.sv
module otp_store #(
  parameter int DEPTH = 8064,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
  import otp_pkg::*;
#(
  parameter int DEPTH = 8064,
  parameter int NIB = 4,
  localparam int DW = 2 * NIB,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           prog_en,
  input  logic [3:0]     mode_sel,
  input  logic           pulse_in,
  input  logic [NIB-1:0] din_lo,
  input  logic [NIB-1:0] din_hi,
  output logic [NIB-1:0] dout_lo,
  output logic [NIB-1:0] dout_hi,
  output logic           dout_oe,
  output logic           addr_oor
);
  otp_op_e       op;
  logic          pulse_q;
  logic          was_wr;
  logic          rise;
  logic          wr_stb;
  logic [AW-1:0] addr;
  logic [DW-1:0] rd_byte;
  logic [DW-1:0] dout_q;

  otp_mode_decode u_dec (
    .en  (prog_en),
    .sel (mode_sel),
    .op  (op)
  );

  assign rise = pulse_in && !pulse_q && prog_en && (op != OP_CLEAR);

  otp_addr_ctr #(.DEPTH(DEPTH), .PULSES_PER_STEP(4)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .clear (op == OP_CLEAR),
    .step  (rise),
    .addr  (addr),
    .oor   (addr_oor)
  );

  assign wr_stb = (op == OP_WRITE) && !was_wr && !addr_oor;

  otp_store #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (wr_stb),
    .addr  (addr),
    .wdata ({din_hi, din_lo}),
    .rdata (rd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      was_wr  <= 1'b0;
      dout_q  <= '0;
      dout_oe <= 1'b0;
    end else begin
      pulse_q <= pulse_in;
      was_wr  <= (op == OP_WRITE);
      dout_oe <= (op == OP_VERIFY);
      dout_q  <= (op == OP_VERIFY) ? rd_byte : '0;
    end
  end

  assign dout_lo = dout_q[NIB-1:0];
  assign dout_hi = dout_q[DW-1:NIB];

  a_r7_oe_only_verify: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> $past(op == OP_VERIFY));
  a_r10_no_write_disabled: assert property (@(posedge clk) disable iff (rst)
    !prog_en |-> !wr_stb);
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
  a_r9_unknown_inhibit: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 4'b0000) |-> (op == OP_INHIBIT));
  a_r8_no_write_oor: assert property (@(posedge clk) disable iff (rst)
    addr_oor |-> !wr_stb);
endmodule

// File: tb/sim_otp_prog_port.sv
module sim_otp_prog_port;
  localparam int DEPTH = 8064;
  localparam logic [3:0] M_CLR = 4'b0101;
  localparam logic [3:0] M_WR  = 4'b1110;
  localparam logic [3:0] M_VF  = 4'b1100;
  localparam logic [3:0] M_INH = 4'b1111;
  localparam logic [3:0] M_INX = 4'b1101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_en = 1'b0;
  logic [3:0] mode_sel = M_INH;
  logic pulse_in = 1'b0;
  logic [3:0] din_lo = '0, din_hi = '0;
  logic [3:0] dout_lo, dout_hi;
  logic dout_oe, addr_oor;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  logic [7:0] m_mem [DEPTH];
  int m_addr = 0, m_sub = 0;
  bit m_oor = 0;
  logic [3:0] cur = M_INH;

  always #10 clk = ~clk;

  otp_prog_port u0 (
    .clk(clk), .rst(rst), .prog_en(prog_en), .mode_sel(mode_sel),
    .pulse_in(pulse_in), .din_lo(din_lo), .din_hi(din_hi),
    .dout_lo(dout_lo), .dout_hi(dout_hi), .dout_oe(dout_oe),
    .addr_oor(addr_oor)
  );

  function automatic int op_of(bit en, logic [3:0] m);
    if (!en) return 0;
    if (m == M_CLR) return 1;
    if (m == M_WR) return 2;
    if (m == M_VF) return 3;
    return 0;
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(logic [3:0] m);
    mode_sel = m;
    cur = m;
    if (op_of(prog_en, m) == 1) begin m_addr = 0; m_sub = 0; m_oor = 0; end
    if (op_of(prog_en, m) == 2 && !m_oor) m_mem[m_addr] = {din_hi, din_lo};
    tick(3);
  endtask

  task automatic pulse();
    pulse_in = 1'b1; tick(1);
    pulse_in = 1'b0; tick(1);
    if (prog_en && op_of(1, cur) != 1) begin
      m_sub++;
      if (m_sub == 4) begin
        m_sub = 0;
        if (m_addr == DEPTH - 1) m_oor = 1; else m_addr++;
      end
    end
  endtask

  task automatic write_byte(logic [7:0] b);
    {din_hi, din_lo} = b;
    set_mode(M_WR);
    set_mode(M_INH);
  endtask

  task automatic read_check(string req);
    set_mode(M_VF);
    check(req, {dout_oe, dout_hi, dout_lo}, {1'b1, m_mem[m_addr]});
  endtask

  task automatic bus_off(string req);
    check(req, {dout_oe, dout_hi, dout_lo}, 9'h000);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++; n_bad++;
        $display("FAIL R4 watchdog actual=%0d expected<190000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] b;
    int k;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check("R1 oe/oor", {7'd0, dout_oe, addr_oor}, 9'd0);
    prog_en = 1'b1;
    // R6 blank location reads FF, R1 address starts at 0
    read_check("R6 blank read at 0 (R1)");
    set_mode(M_INH);
    bus_off("R7 inhibit releases bus");

    // R5 R4 directed sequential writes
    set_mode(M_CLR);
    for (int a = 0; a < 24; a++) begin
      write_byte(8'(a * 37 + 5));
      bus_off("R7 after write bus off");
      for (int p = 0; p < 4; p++) pulse();
    end
    set_mode(M_CLR);
    for (int a = 0; a < 24; a++) begin
      read_check("R5 readback of written byte");
      for (int p = 0; p < 4; p++) pulse();   // R4 counting in verify mode
    end

    // R2 other inhibit code 11?1, write mode held drives nothing (R7)
    set_mode(M_INX);
    bus_off("R2 inhibit with MD1 low");
    {din_hi, din_lo} = 8'h3C;
    set_mode(M_WR);
    bus_off("R7 bus off in write mode");
    set_mode(M_INH);

    // R3 partial pulses then clear
    set_mode(M_CLR);
    for (int p = 0; p < 3; p++) pulse();
    set_mode(M_CLR);
    pulse();
    read_check("R3 clear drops partial sub-count");

    // R9 unknown code: no write, no drive
    set_mode(M_CLR);
    {din_hi, din_lo} = 8'h00;
    set_mode(4'b0000);
    bus_off("R9 unknown code bus off");
    set_mode(4'b1010);
    set_mode(M_INH);
    read_check("R9 unknown code stored nothing");

    // R10 enable low: no clear, no write, no count, no drive
    set_mode(M_CLR);
    pulse(); pulse(); pulse(); pulse();
    prog_en = 1'b0;
    set_mode(M_CLR);
    {din_hi, din_lo} = 8'h55;
    set_mode(M_WR);
    for (int p = 0; p < 8; p++) pulse();
    set_mode(M_VF);
    bus_off("R10 disabled verify no drive");
    set_mode(M_INH);
    prog_en = 1'b1;
    read_check("R10 disabled port changed nothing");

    // Random mix
    set_mode(M_CLR);
    for (int it = 0; it < 150; it++) begin
      k = $urandom_range(0, 3);
      case (k)
        0: begin b = 8'($urandom); write_byte(b); end
        1: read_check("R6 random verify");
        2: begin
          set_mode(($urandom_range(0, 1) == 0) ? M_INH : 4'b0110);
          bus_off("R7 random non-verify mode");
          for (int p = 0; p < $urandom_range(1, 6); p++) pulse();
        end
        default: begin
          set_mode(M_VF);
          for (int p = 0; p < $urandom_range(1, 6); p++) pulse();
          read_check("R4 random pulses in verify");
        end
      endcase
    end

    // R8 saturation at last location
    set_mode(M_CLR);
    set_mode(M_INH);
    while (m_addr < DEPTH - 1) pulse();
    check("R8 no flag at last location", {8'd0, addr_oor}, 9'd0);
    write_byte(8'hA5);
    pulse(); pulse(); pulse(); pulse();
    check("R8 flag after passing end", {8'd0, addr_oor}, 9'd1);
    write_byte(8'h12);
    read_check("R8 saturated address keeps last byte");
    pulse(); pulse(); pulse(); pulse();
    read_check("R8 still saturated");
    set_mode(M_CLR);
    check("R3 clear lowers flag", {8'd0, addr_oor}, 9'd0);
    read_check("R3 clear returns to location 0");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule